// File: doc/BRIEF.md
# Page Permission Fault Checker

This block decides whether a memory access that has already hit in the translation cache may go ahead. It takes the permission bits of the matching entry and the processor's current privilege state. If the access is allowed, it forms the physical address. If not, it raises a page fault and produces the fields a fault report needs: the access type to report, whether the access ran in user mode, a present indication, and a cause code that names which rule was broken.

The block is purely combinational and sits directly after the hit logic. Two points differ from a naive permission check. First, the write-protect control bit makes supervisor writes to read-only pages fault as well. Second, a read made with the intent to store later is checked as a write and reported as a write fault. Only one fault is reported per access, chosen by a fixed priority.

Top module: `page_perm_check`

## Requirements
- R1: An access is in user mode exactly when `cpl_i` equals 3 and `sup_ovr_i` is 0. On a fault, `fault_user_o` carries that user-mode value; with no fault it is 0.
- R2: A user-mode access to an entry whose `ent_user_i` is 0 faults for every access type, with cause code 1. The reported type is the normalised access type (read 0, write 1, store-intent read 2).
- R3: A write (`acc_type_i` = 1) in user mode to an entry whose `ent_wr_i` is 0 faults with cause code 2 and reported type 1.
- R4: A supervisor-mode write to an entry with `ent_wr_i` = 0 faults only when `wp_i` is 1. When `wp_i` is 0, no access in supervisor mode ever faults.
- R5: A store-intent read (`acc_type_i` = 2) is checked with the write rule. When that check fails, the fault has cause code 3 and the reported type is forced to write (1).
- R6: A plain read (`acc_type_i` = 0) never faults because the entry is not writable.
- R7: The rules are applied in priority order: user-bit violation (cause 1), then write violation (cause 2), then store-intent violation (cause 3). Cause 0 means no fault.
- R8: With no fault, `pa_o` equals `{ent_ppn_i, va_off_i}` and `pa_vld_o` is 1. With a fault, `pa_o` is 0 and `pa_vld_o` is 0.
- R9: `fault_present_o` is 1 exactly when `fault_o` is 1. With no fault, `fault_type_o` is 0.
- R10: The unused access code 3 is treated in every respect as a plain read, including the reported type 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_type_i | input | 2 | Access kind: 0 read, 1 write, 2 store-intent read, 3 treated as read |
| cpl_i | input | 2 | Current privilege level |
| sup_ovr_i | input | 1 | Forces supervisor treatment of the access |
| wp_i | input | 1 | Write-protect control bit |
| ent_user_i | input | 1 | Entry allows user-mode access |
| ent_wr_i | input | 1 | Entry is writable |
| ent_ppn_i | input | PPN_W | Entry physical page number |
| va_off_i | input | OFF_W | Untranslated page offset |
| fault_o | output | 1 | Page fault raised |
| fault_type_o | output | 2 | Access type to report (0 read, 1 write, 2 store-intent read) |
| fault_user_o | output | 1 | User-mode flag for the error code |
| fault_present_o | output | 1 | Present indication for the error code |
| fault_cause_o | output | 2 | 0 none, 1 user bit, 2 write, 3 store-intent write |
| pa_o | output | PPN_W+OFF_W | Physical address when allowed, else 0 |
| pa_vld_o | output | 1 | Physical address is valid |

## Verification
The assertions assume that every input is a settled two-valued level and that the outputs are examined only once the combinational logic has finished evaluating. They also assume that all four access codes may appear, with code 3 carrying no special meaning. The bench respects these assumptions: it changes inputs only on the falling clock edge and compares outputs only before the next rising edge. It sweeps the whole space of control inputs, so every privilege level, override, write-protect setting, entry bit and access code is exercised together, alongside directed cases aimed at each rule.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_RSI = 2'd2
  } acc_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_USER = 2'd1,
    CAUSE_WR   = 2'd2,
    CAUSE_RSI  = 2'd3
  } cause_t;

  localparam logic [1:0] USER_CPL = 2'd3;

  // code 3 is unused and folds onto a plain read
  function automatic acc_t norm_acc(input logic [1:0] raw);
    case (raw)
      2'd1:    norm_acc = ACC_WR;
      2'd2:    norm_acc = ACC_RSI;
      default: norm_acc = ACC_RD;
    endcase
  endfunction
endpackage

// File: rtl/pfc_priv_decode.sv
module pfc_priv_decode
  import pfc_pkg::*;
(
  input  logic [1:0] cpl_i,
  input  logic       sup_ovr_i,
  input  logic [1:0] acc_raw_i,
  output logic       user_mode_o,
  output acc_t       acc_o
);
  assign user_mode_o = (cpl_i == USER_CPL) && !sup_ovr_i;
  assign acc_o       = norm_acc(acc_raw_i);
endmodule

// File: rtl/pfc_perm_eval.sv
module pfc_perm_eval
  import pfc_pkg::*;
(
  input  logic user_mode_i,
  input  acc_t acc_i,
  input  logic wp_i,
  input  logic ent_user_i,
  input  logic ent_wr_i,
  output logic user_viol_o,
  output logic wr_viol_o,
  output logic rsi_viol_o
);
  logic bad_write;

  assign bad_write   = !ent_wr_i && (user_mode_i || wp_i);
  assign user_viol_o = user_mode_i && !ent_user_i;
  assign wr_viol_o   = (acc_i == ACC_WR) && bad_write;
  assign rsi_viol_o  = (acc_i == ACC_RSI) && bad_write;
endmodule

// File: rtl/pfc_fault_sel.sv
module pfc_fault_sel
  import pfc_pkg::*;
(
  input  logic   user_mode_i,
  input  acc_t   acc_i,
  input  logic   user_viol_i,
  input  logic   wr_viol_i,
  input  logic   rsi_viol_i,
  output logic   fault_o,
  output acc_t   type_o,
  output logic   user_o,
  output cause_t cause_o
);
  always_comb begin
    fault_o = 1'b1;
    type_o  = acc_i;
    cause_o = CAUSE_NONE;
    if (user_viol_i) begin
      cause_o = CAUSE_USER;
    end else if (wr_viol_i) begin
      cause_o = CAUSE_WR;
    end else if (rsi_viol_i) begin
      cause_o = CAUSE_RSI;
      type_o  = ACC_WR;
    end else begin
      fault_o = 1'b0;
      type_o  = ACC_RD;
    end
    user_o = fault_o && user_mode_i;
  end
endmodule

// File: rtl/pfc_pa_compose.sv
module pfc_pa_compose #(
  parameter int PPN_W = 40,
  parameter int OFF_W = 12,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             block_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             vld_o
);
  assign vld_o = !block_i;
  assign pa_o  = block_i ? '0 : {ppn_i, off_i};
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pfc_pkg::*;
#(
  parameter int PPN_W = 40,
  parameter int OFF_W = 12,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [1:0]       acc_type_i,
  input  logic [1:0]       cpl_i,
  input  logic             sup_ovr_i,
  input  logic             wp_i,
  input  logic             ent_user_i,
  input  logic             ent_wr_i,
  input  logic [PPN_W-1:0] ent_ppn_i,
  input  logic [OFF_W-1:0] va_off_i,
  output logic             fault_o,
  output logic [1:0]       fault_type_o,
  output logic             fault_user_o,
  output logic             fault_present_o,
  output logic [1:0]       fault_cause_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             pa_vld_o
);
  logic   user_mode;
  acc_t   acc;
  logic   user_viol, wr_viol, rsi_viol;
  acc_t   rep_type;
  cause_t cause;

  pfc_priv_decode u_dec (
    .cpl_i       (cpl_i),
    .sup_ovr_i   (sup_ovr_i),
    .acc_raw_i   (acc_type_i),
    .user_mode_o (user_mode),
    .acc_o       (acc)
  );

  pfc_perm_eval u_eval (
    .user_mode_i (user_mode),
    .acc_i       (acc),
    .wp_i        (wp_i),
    .ent_user_i  (ent_user_i),
    .ent_wr_i    (ent_wr_i),
    .user_viol_o (user_viol),
    .wr_viol_o   (wr_viol),
    .rsi_viol_o  (rsi_viol)
  );

  pfc_fault_sel u_sel (
    .user_mode_i (user_mode),
    .acc_i       (acc),
    .user_viol_i (user_viol),
    .wr_viol_i   (wr_viol),
    .rsi_viol_i  (rsi_viol),
    .fault_o     (fault_o),
    .type_o      (rep_type),
    .user_o      (fault_user_o),
    .cause_o     (cause)
  );

  pfc_pa_compose #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_pa (
    .ppn_i   (ent_ppn_i),
    .off_i   (va_off_i),
    .block_i (fault_o),
    .pa_o    (pa_o),
    .vld_o   (pa_vld_o)
  );

  assign fault_type_o    = rep_type;
  assign fault_cause_o   = cause;
  assign fault_present_o = fault_o;
endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva #(
  parameter int PPN_W = 40,
  parameter int OFF_W = 12,
  localparam int PA_W = PPN_W + OFF_W
) (
  input logic [1:0]       acc_type_i,
  input logic [1:0]       cpl_i,
  input logic             sup_ovr_i,
  input logic             wp_i,
  input logic             ent_user_i,
  input logic             ent_wr_i,
  input logic [PPN_W-1:0] ent_ppn_i,
  input logic [OFF_W-1:0] va_off_i,
  input logic             fault_o,
  input logic [1:0]       fault_type_o,
  input logic             fault_user_o,
  input logic             fault_present_o,
  input logic [1:0]       fault_cause_o,
  input logic [PA_W-1:0]  pa_o,
  input logic             pa_vld_o
);
  logic um;
  assign um = (cpl_i == 2'd3) && !sup_ovr_i;

  always_comb begin
    assert_user_flag_R1: assert (!fault_o || fault_user_o == um);
    assert_user_bit_R2: assert (!(um && !ent_user_i) || (fault_o && fault_cause_o == 2'd1));
    assert_sup_no_wp_R4: assert (um || wp_i || !fault_o);
    assert_rsi_as_write_R5: assert (!(fault_o && fault_cause_o == 2'd3) || (acc_type_i == 2'd2 && fault_type_o == 2'd1));
    assert_read_ok_R6: assert (!(acc_type_i[0] == acc_type_i[1] && (!um || ent_user_i)) || !fault_o);
    assert_cause_fault_R7: assert ((fault_cause_o != 2'd0) == fault_o);
    assert_pa_R8: assert (fault_o ? (pa_o == '0 && !pa_vld_o) : (pa_vld_o && pa_o == {ent_ppn_i, va_off_i}));
    assert_present_R9: assert (fault_present_o == fault_o && (fault_o || (fault_type_o == 2'd0 && !fault_user_o)));
  end
endmodule

bind page_perm_check page_perm_check_sva #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_sva (.*);

// File: tb/page_perm_check_bench.sv
module page_perm_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PPN_W = 40;
  localparam int OFF_W = 12;
  localparam int PA_W  = PPN_W + OFF_W;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]       acc_type_i, cpl_i;
  logic             sup_ovr_i, wp_i, ent_user_i, ent_wr_i;
  logic [PPN_W-1:0] ent_ppn_i;
  logic [OFF_W-1:0] va_off_i;
  logic             fault_o, fault_user_o, fault_present_o, pa_vld_o;
  logic [1:0]       fault_type_o, fault_cause_o;
  logic [PA_W-1:0]  pa_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  page_perm_check #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_page_perm_check (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] acc, input logic [1:0] cpl, input logic ovr,
                       input logic wp, input logic usr, input logic wr);
    @(negedge clk);
    acc_type_i = acc; cpl_i = cpl; sup_ovr_i = ovr; wp_i = wp;
    ent_user_i = usr; ent_wr_i = wr;
    ent_ppn_i  = {8'hA5, 32'(cpl) ^ 32'h1234_5678};
    va_off_i   = 12'h3C0 | 12'(acc);
    #(CLK_PERIOD/4);
  endtask

  // expected outputs from the requirement text
  task automatic check_model(input string req);
    logic um, bw, f;
    logic [1:0] a, c, t;
    um = (cpl_i == 2'd3) && !sup_ovr_i;
    a  = (acc_type_i == 2'd3) ? 2'd0 : acc_type_i;
    bw = !ent_wr_i && (um || wp_i);
    c = 2'd0; t = 2'd0;
    if (um && !ent_user_i)      begin c = 2'd1; t = a;    end
    else if (a == 2'd1 && bw)   begin c = 2'd2; t = 2'd1; end
    else if (a == 2'd2 && bw)   begin c = 2'd3; t = 2'd1; end
    f = (c != 2'd0);
    chk(req, "fault",   64'(fault_o), 64'(f));
    chk(req, "cause",   64'(fault_cause_o), 64'(c));
    chk(req, "type",    64'(fault_type_o), 64'(t));
    chk(req, "user",    64'(fault_user_o), 64'(f && um));
    chk(req, "present", 64'(fault_present_o), 64'(f));
    chk(req, "pa_vld",  64'(pa_vld_o), 64'(!f));
    chk(req, "pa",      64'(pa_o), f ? 64'd0 : 64'({ent_ppn_i, va_off_i}));
  endtask

  task automatic t_reset_state;
    apply(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9", "idle fault", 64'(fault_o), 64'd0);
    chk("R8", "idle pa_vld", 64'(pa_vld_o), 64'd1);
  endtask

  task automatic t_user_mode_R1;
    apply(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1); // override: supervisor
    chk("R1", "override fault", 64'(fault_o), 64'd0);
    apply(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", "cpl2 fault", 64'(fault_o), 64'd0);
    apply(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", "cpl3 user flag", 64'(fault_user_o), 64'd1);
  endtask

  task automatic t_user_bit_R2;
    apply(2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2", "cause", 64'(fault_cause_o), 64'd1);
    chk("R2", "type kept", 64'(fault_type_o), 64'd2);
    apply(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", "write type", 64'(fault_type_o), 64'd1);
  endtask

  task automatic t_user_write_R3;
    apply(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3", "cause", 64'(fault_cause_o), 64'd2);
    chk("R3", "type", 64'(fault_type_o), 64'd1);
  endtask

  task automatic t_wp_R4;
    apply(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", "sup write wp0", 64'(fault_o), 64'd0);
    apply(2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4", "sup write wp1", 64'(fault_cause_o), 64'd2);
    chk("R4", "sup user flag", 64'(fault_user_o), 64'd0);
  endtask

  task automatic t_rsi_R5;
    apply(2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5", "cause", 64'(fault_cause_o), 64'd3);
    chk("R5", "forced type", 64'(fault_type_o), 64'd1);
    apply(2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", "writable ok", 64'(fault_o), 64'd0);
  endtask

  task automatic t_read_R6;
    apply(2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6", "read ro page", 64'(fault_o), 64'd0);
  endtask

  task automatic t_priority_R7;
    apply(2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7", "user wins", 64'(fault_cause_o), 64'd1);
  endtask

  task automatic t_pa_R8;
    apply(2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8", "pa", 64'(pa_o), 64'({ent_ppn_i, va_off_i}));
    apply(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8", "pa blocked", 64'(pa_o), 64'd0);
  endtask

  task automatic t_code3_R10;
    apply(2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10", "no write check", 64'(fault_o), 64'd0);
    apply(2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "reported read", 64'(fault_type_o), 64'd0);
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 256; v++) begin
      apply(v[1:0], v[3:2], v[4], v[5], v[6], v[7]);
      check_model("R1..R10 sweep");
    end
  endtask

  initial begin
    acc_type_i = '0; cpl_i = '0; sup_ovr_i = 0; wp_i = 0;
    ent_user_i = 1; ent_wr_i = 1; ent_ppn_i = '0; va_off_i = '0;
    t_reset_state();
    t_user_mode_R1();
    t_user_bit_R2();
    t_user_write_R3();
    t_wp_R4();
    t_rsi_R5();
    t_read_R6();
    t_priority_R7();
    t_pa_R8();
    t_code3_R10();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule